// File: doc/BRIEF.md
# HDLC Receive Deframer and Validator

The block takes a bit-serial HDLC line, qualified by a bit strobe, and turns it back into packets. It looks for the flag octet at every bit position. Inside a frame it strips the zeros that the sender inserted, spots abort runs and assembles bytes, least significant bit first. It runs the 16-bit CCITT check sequence over everything between the flags and counts the de-stuffed bits of each frame.

The bytes of a frame leave as a stream with a valid strobe, a last tag and a bad-packet tag. Frames that pass are delivered without their two check-sequence bytes. Frames that are too short to carry anything are swallowed whole. Frames that are malformed or damaged are delivered with their final byte flagged as bad.

A frame is classified by its de-stuffed bit count. Below 25 bits it is dropped. From 25 to 31 bits it is malformed. At 32 bits or more it is judged by the check-sequence residue. Each byte is held back until three newer complete bytes of the same frame exist. This is what lets a short frame vanish, the check-sequence bytes be withheld, and the tags land on the true final byte.

Top module: `hdlc_rx_deframer`

## Requirements
- R1: While hunting, the receiver opens a frame on the bit pattern 0,1,1,1,1,1,1,0 (octet 0x7E) at any bit offset. Bits received before the first such pattern produce no output.
- R2: Inside a frame, a 0 that follows five consecutive 1s is removed. It counts neither as data nor toward the frame's bit length.
- R3: The check register is preset to 0xFFFF at every flag that opens a frame. It is updated LSB-first with the reflected polynomial x^16+x^12+x^5+1 (0x8408) over all de-stuffed bits, check bytes included. The frame passes only if the final register equals 0xF0B8.
- R4: A passing frame of 32 or more bits delivers every complete byte except the final two. `byte_last` is 1 on the final delivered byte and `byte_bad` is 0 throughout.
- R5: A frame with fewer than 25 de-stuffed bits between its flags produces no output at all.
- R6: A frame of 25 to 31 bits delivers its three complete bytes with `byte_last` and `byte_bad` both 1 on the third. Trailing bits that do not fill a byte are dropped.
- R7: A frame of 32 or more bits that fails the check delivers all of its complete bytes, check bytes included, with `byte_last` and `byte_bad` both 1 on the final one.
- R8: Six consecutive 1s inside a frame, followed by a further 1, abort the frame and return the receiver to hunting. Bytes already delivered stay delivered, and no further byte of that frame leaves. `frame_abort` pulses for one cycle only if the frame had already delivered a byte. When the last data bit before the abort run is 0, the bytes delivered are all data bytes except the final four.
- R9: Bytes leave in arrival order, and the first received bit of a byte is its bit 0. No byte of a frame leaves before that frame's 32nd de-stuffed bit.
- R10: After reset the receiver is hunting and every output is 0.
- R11: When `bit_en` is 0, `bit_in` is ignored.
- R12: The flag that closes a frame also opens the next one, so frames separated by a single flag are each received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Serial line bit |
| byte_vld | output | 1 | A byte is presented this cycle |
| byte_data | output | 8 | Delivered byte |
| byte_last | output | 1 | Final delivered byte of a frame |
| byte_bad | output | 1 | Frame failed the length or check test (only with `byte_last`) |
| frame_abort | output | 1 | One-cycle pulse: a frame that had delivered bytes was aborted |

## Verification
The bench probes the length thresholds bit by bit: 24, 25, 31 and 32 de-stuffed bits, plus a one-byte passing frame. A design that counted stuffed zeros or shifted a threshold would deliver a short frame or drop a malformed one. Payloads full of 0xFF and 0x7E force heavy zero removal. A receiver that mis-destuffs corrupts the bytes or sees false flags, and one that misses the CRC preset on a shared flag fails the second of two back-to-back frames. Aborts are sent after both four and six data bytes, which catches an abort pulse with nothing delivered and partial bytes leaking out. Strobe gaps filled with toggling junk bits catch a design that samples `bit_in` unqualified.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int BYTE_W        = 8;
    localparam int HOLD_BYTES    = 3;
    localparam int WIN_BITS      = 6;
    localparam int MIN_KEEP_BITS = 25;
    localparam int MIN_GOOD_BITS = 32;

    localparam logic [15:0] CRC_PRESET   = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REV = 16'h8408;
    localparam logic [15:0] CRC_RESIDUE  = 16'hF0B8;

    typedef logic [BYTE_W-1:0] byte_t;

    // Events produced by the line stage for one qualified bit
    typedef struct packed {
        logic flag;
        logic abort;
        logic dvld;
        logic dbit;
    } line_ev_t;

    // Frame close request handed to the output stage
    typedef struct packed {
        logic                        vld;
        logic                        good;
        byte_t [HOLD_BYTES-1:0]      held;
    } close_t;

    typedef struct packed {
        logic  vld;
        byte_t data;
        logic  last;
        logic  bad;
    } out_beat_t;

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic [15:0] n;
        n = c >> 1;
        if (c[0] ^ b) n = n ^ CRC_POLY_REV;
        return n;
    endfunction

endpackage

// File: rtl/hdlc_rx_line.sv
module hdlc_rx_line
    import hdlc_rx_pkg::*;
#(
    parameter int WIN = WIN_BITS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     bit_en,
    input  logic     bit_in,
    output line_ev_t ev
);
    localparam int OW  = 3;
    localparam int WCW = $clog2(WIN + 1);

    logic [OW-1:0]  ones_q;
    logic           in_frame_q;
    logic [WIN-1:0] win_q;
    logic [WCW-1:0] wcnt_q;

    logic stuffed;
    logic cand;

    always_comb begin
        ev       = '0;
        ev.flag  = bit_en && !bit_in && (ones_q == OW'(6));
        ev.abort = bit_en &&  bit_in && (ones_q == OW'(6)) && in_frame_q;
        stuffed  = bit_en && !bit_in && (ones_q == OW'(5));
        cand     = in_frame_q && bit_en && !stuffed && !ev.flag
                   && !(bit_in && (ones_q >= OW'(5)));
        ev.dvld  = cand && (wcnt_q == WCW'(WIN));
        ev.dbit  = win_q[WIN-1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ones_q     <= '0;
            in_frame_q <= 1'b0;
            win_q      <= '0;
            wcnt_q     <= '0;
        end else if (bit_en) begin
            if (bit_in) begin
                if (ones_q != OW'(7)) ones_q <= ones_q + 1'b1;
            end else begin
                ones_q <= '0;
            end
            if (ev.flag) begin
                in_frame_q <= 1'b1;
                wcnt_q     <= '0;
            end else if (ev.abort) begin
                in_frame_q <= 1'b0;
                wcnt_q     <= '0;
            end else if (cand) begin
                win_q <= {win_q[WIN-2:0], bit_in};
                if (wcnt_q != WCW'(WIN)) wcnt_q <= wcnt_q + 1'b1;
            end
        end
    end

    AST_FLAG_OPENS: assert property (@(posedge clk) disable iff (rst)
        ev.flag |=> (in_frame_q && wcnt_q == '0)); // R1
    AST_ABORT_HUNTS: assert property (@(posedge clk) disable iff (rst)
        ev.abort |=> !in_frame_q); // R8
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
        !bit_en |=> ($stable(ones_q) && $stable(win_q) && $stable(in_frame_q))); // R11

endmodule

// File: rtl/hdlc_rx_frame.sv
module hdlc_rx_frame
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HOLD  = HOLD_BYTES
) (
    input  logic     clk,
    input  logic     rst,
    input  line_ev_t ev,
    output close_t   cls,
    output logic     emit_vld,
    output byte_t    emit_data,
    output logic     abort_out
);
    localparam int HCW = $clog2(HOLD + 1);
    localparam int BPW = $clog2(BYTE_W);

    logic [15:0]          crc_q;
    logic [CNT_W-1:0]     nbits_q;
    byte_t                shf_q;
    logic [BPW-1:0]       bpos_q;
    byte_t [HOLD-1:0]     hold_q;
    logic [HCW-1:0]       hcnt_q;
    logic                 sent_q;

    byte_t new_byte;
    logic  byte_done;

    always_comb begin
        new_byte  = {ev.dbit, shf_q[BYTE_W-1:1]};
        byte_done = ev.dvld && (bpos_q == BPW'(BYTE_W - 1));
        cls.vld   = ev.flag && (nbits_q >= CNT_W'(MIN_KEEP_BITS));
        cls.good  = (nbits_q >= CNT_W'(MIN_GOOD_BITS)) && (crc_q == CRC_RESIDUE);
        cls.held  = hold_q;
        emit_vld  = byte_done && (hcnt_q == HCW'(HOLD));
        emit_data = hold_q[0];
        abort_out = ev.abort && sent_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            crc_q   <= CRC_PRESET;
            nbits_q <= '0;
            shf_q   <= '0;
            bpos_q  <= '0;
            hold_q  <= '0;
            hcnt_q  <= '0;
            sent_q  <= 1'b0;
        end else if (ev.flag || ev.abort) begin
            crc_q   <= CRC_PRESET;
            nbits_q <= '0;
            bpos_q  <= '0;
            hcnt_q  <= '0;
            sent_q  <= 1'b0;
        end else if (ev.dvld) begin
            crc_q  <= crc_step(crc_q, ev.dbit);
            if (nbits_q != '1) nbits_q <= nbits_q + 1'b1;
            shf_q  <= new_byte;
            bpos_q <= bpos_q + 1'b1;
            if (byte_done) begin
                if (hcnt_q == HCW'(HOLD)) begin
                    hold_q <= {new_byte, hold_q[HOLD-1:1]};
                    sent_q <= 1'b1;
                end else begin
                    for (int i = 0; i < HOLD; i++) begin
                        if (hcnt_q == HCW'(i)) hold_q[i] <= new_byte;
                    end
                    hcnt_q <= hcnt_q + 1'b1;
                end
            end
        end
    end

    AST_HOLDBACK: assert property (@(posedge clk) disable iff (rst)
        emit_vld |-> (nbits_q >= CNT_W'(MIN_GOOD_BITS - 1))); // R9
    AST_PRESET_ON_FLAG: assert property (@(posedge clk) disable iff (rst)
        ev.flag |=> (crc_q == CRC_PRESET && nbits_q == '0)); // R3
    AST_ABORT_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        ev.abort |=> (hcnt_q == '0 && !sent_q)); // R8

endmodule

// File: rtl/hdlc_rx_out.sv
module hdlc_rx_out
    import hdlc_rx_pkg::*;
#(
    parameter int HOLD = HOLD_BYTES
) (
    input  logic      clk,
    input  logic      rst,
    input  close_t    cls,
    input  logic      emit_vld,
    input  byte_t     emit_data,
    input  logic      abort_in,
    output out_beat_t beat_q,
    output logic      abort_q
);
    localparam int DCW = $clog2(HOLD);

    byte_t [HOLD-2:0] drain_q;
    logic [DCW-1:0]   dcnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q  <= '0;
            abort_q <= 1'b0;
            drain_q <= '0;
            dcnt_q  <= '0;
        end else begin
            beat_q  <= '0;
            abort_q <= abort_in;
            if (cls.vld) begin
                beat_q.vld  <= 1'b1;
                beat_q.data <= cls.held[0];
                if (cls.good) begin
                    beat_q.last <= 1'b1;
                end else begin
                    drain_q <= cls.held[HOLD-1:1];
                    dcnt_q  <= DCW'(HOLD - 1);
                end
            end else if (dcnt_q != '0) begin
                beat_q.vld  <= 1'b1;
                beat_q.data <= drain_q[0];
                drain_q     <= drain_q >> BYTE_W;
                dcnt_q      <= dcnt_q - 1'b1;
                if (dcnt_q == DCW'(1)) begin
                    beat_q.last <= 1'b1;
                    beat_q.bad  <= 1'b1;
                end
            end else if (emit_vld) begin
                beat_q.vld  <= 1'b1;
                beat_q.data <= emit_data;
            end
        end
    end

    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (rst)
        emit_vld |-> (dcnt_q == '0 && !cls.vld)); // R9
    AST_LAST_THEN_GAP: assert property (@(posedge clk) disable iff (rst)
        beat_q.last |=> !beat_q.vld); // R4
    AST_BAD_ON_LAST: assert property (@(posedge clk) disable iff (rst)
        beat_q.bad |-> (beat_q.last && beat_q.vld)); // R7

endmodule

// File: rtl/hdlc_rx_deframer.sv
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_en,
    input  logic       bit_in,
    output logic       byte_vld,
    output logic [7:0] byte_data,
    output logic       byte_last,
    output logic       byte_bad,
    output logic       frame_abort
);
    line_ev_t  ev;
    close_t    cls;
    logic      emit_vld;
    byte_t     emit_data;
    logic      abort_evt;
    out_beat_t beat;

    hdlc_rx_line #(.WIN(WIN_BITS)) line_i (
        .clk    (clk),
        .rst    (rst),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .ev     (ev)
    );

    hdlc_rx_frame #(.CNT_W(CNT_W), .HOLD(HOLD_BYTES)) frame_i (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .cls       (cls),
        .emit_vld  (emit_vld),
        .emit_data (emit_data),
        .abort_out (abort_evt)
    );

    hdlc_rx_out #(.HOLD(HOLD_BYTES)) out_i (
        .clk       (clk),
        .rst       (rst),
        .cls       (cls),
        .emit_vld  (emit_vld),
        .emit_data (emit_data),
        .abort_in  (abort_evt),
        .beat_q    (beat),
        .abort_q   (frame_abort)
    );

    assign byte_vld  = beat.vld;
    assign byte_data = beat.data;
    assign byte_last = beat.last;
    assign byte_bad  = beat.bad;

    AST_ABORT_NOT_BYTE: assert property (@(posedge clk) disable iff (rst)
        frame_abort |-> !byte_vld); // R8

endmodule

// File: tb/hdlc_rx_deframer_tb_top.sv
module hdlc_rx_deframer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam int VEC_N      = 9;
    // fields: kind, n, seed, gap, expected byte count
    // kind 0 good frame of n bytes, 1 corrupted frame, 2 raw n bits, 3 stuffing-heavy good
    localparam logic [39:0] VEC [VEC_N] = '{
        {8'd0, 8'd2,  8'd11, 8'd0, 8'd2},
        {8'd0, 8'd5,  8'd22, 8'd2, 8'd5},
        {8'd0, 8'd1,  8'd5,  8'd0, 8'd0},
        {8'd1, 8'd3,  8'd33, 8'd1, 8'd5},
        {8'd2, 8'd24, 8'd44, 8'd0, 8'd0},
        {8'd2, 8'd25, 8'd55, 8'd0, 8'd3},
        {8'd2, 8'd31, 8'd66, 8'd1, 8'd3},
        {8'd2, 8'd32, 8'd77, 8'd0, 8'd4},
        {8'd3, 8'd4,  8'd0,  8'd0, 8'd4}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0;
    logic bit_in = 1'b0;
    logic       byte_vld;
    logic [7:0] byte_data;
    logic       byte_last;
    logic       byte_bad;
    logic       frame_abort;

    hdlc_rx_deframer dut_i (
        .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_last(byte_last),
        .byte_bad(byte_bad), .frame_abort(frame_abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0;
    int fails  = 0;

    logic [7:0] cap_d [0:255];
    logic       cap_l [0:255];
    logic       cap_b [0:255];
    int cap_n  = 0;
    int cap_ab = 0;

    logic [7:0] exp_d [0:255];
    logic       exp_l [0:255];
    logic       exp_b [0:255];
    int exp_n = 0;

    logic fb [0:1023];
    int   fbn = 0;
    logic tx [0:8191];
    int   txn = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (byte_vld) begin
                if (cap_n < 256) begin
                    cap_d[cap_n] = byte_data;
                    cap_l[cap_n] = byte_last;
                    cap_b[cap_n] = byte_bad;
                end
                cap_n++;
            end
            if (frame_abort) cap_ab++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    function automatic logic [7:0] pat(input int kind, input int seed, input int i);
        if (kind == 3) return (i % 2 == 1) ? 8'h7E : 8'hFF;
        return 8'(seed * (i + 3) + i * 29 + 7);
    endfunction

    task automatic fb_put(input logic b);
        fb[fbn] = b;
        fbn++;
    endtask

    task automatic fb_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) fb_put(v[i]);
    endtask

    function automatic logic [15:0] crc_bits(input int n);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            logic fbk;
            fbk = c[0] ^ fb[i];
            c = c >> 1;
            if (fbk) c = c ^ 16'h8408;
        end
        return c;
    endfunction

    task automatic fb_add_fcs();
        logic [15:0] c;
        c = ~crc_bits(fbn);
        for (int i = 0; i < 16; i++) fb_put(c[i]);
    endtask

    task automatic tx_put(input logic b);
        tx[txn] = b;
        txn++;
    endtask

    task automatic tx_flag();
        tx_put(1'b0);
        for (int i = 0; i < 6; i++) tx_put(1'b1);
        tx_put(1'b0);
    endtask

    task automatic tx_body();
        int ones;
        ones = 0;
        for (int i = 0; i < fbn; i++) begin
            tx_put(fb[i]);
            if (fb[i]) ones++; else ones = 0;
            if (ones == 5) begin
                tx_put(1'b0);
                ones = 0;
            end
        end
    endtask

    task automatic tx_abort();
        for (int i = 0; i < 8; i++) tx_put(1'b1);
    endtask

    task automatic play(input int gap);
        for (int i = 0; i < txn; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            bit_in = tx[i];
            for (int g = 0; g < gap; g++) begin
                @(negedge clk);
                bit_en = 1'b0;
                bit_in = ~bit_in;
            end
        end
        @(negedge clk);
        bit_en = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic start_case();
        @(negedge clk);
        rst = 1'b1;
        bit_en = 1'b0;
        repeat (2) @(negedge clk);
        cap_n = 0;
        cap_ab = 0;
        exp_n = 0;
        txn = 0;
        fbn = 0;
        rst = 1'b0;
    endtask

    task automatic expect_from_fb();
        int nb;
        logic good;
        if (fbn >= 25) begin
            nb = fbn / 8;
            good = (fbn >= 32) && (crc_bits(fbn) == 16'hF0B8);
            if (good) nb -= 2;
            for (int j = 0; j < nb; j++) begin
                logic [7:0] v;
                for (int b = 0; b < 8; b++) v[b] = fb[8*j + b];
                exp_d[exp_n] = v;
                exp_l[exp_n] = (j == nb - 1);
                exp_b[exp_n] = (j == nb - 1) && !good;
                exp_n++;
            end
        end
    endtask

    task automatic expect_prefix(input int nb);
        for (int j = 0; j < nb; j++) begin
            logic [7:0] v;
            for (int b = 0; b < 8; b++) v[b] = fb[8*j + b];
            exp_d[exp_n] = v;
            exp_l[exp_n] = 1'b0;
            exp_b[exp_n] = 1'b0;
            exp_n++;
        end
    endtask

    task automatic compare_stream(input string req);
        check(cap_n == exp_n, req, "byte count", cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n && i < 256; i++) begin
            check(cap_d[i] == exp_d[i], req, "byte data", cap_d[i], exp_d[i]);
            check(cap_l[i] == exp_l[i], req, "last tag", cap_l[i], exp_l[i]);
            check(cap_b[i] == exp_b[i], req, "bad tag", cap_b[i], exp_b[i]);
        end
    endtask

    task automatic good_frame(input int seed, input int n);
        fbn = 0;
        for (int i = 0; i < n; i++) fb_byte(pat(0, seed, i));
        fb_add_fcs();
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(byte_vld == 1'b0,    "R10", "byte_vld after reset", byte_vld, 0);
        check(byte_last == 1'b0,   "R10", "byte_last after reset", byte_last, 0);
        check(byte_bad == 1'b0,    "R10", "byte_bad after reset", byte_bad, 0);
        check(frame_abort == 1'b0, "R10", "frame_abort after reset", frame_abort, 0);

        // Vector table walk
        for (int v = 0; v < VEC_N; v++) begin
            int kind, n, seed, gap, ecnt;
            string tag;
            kind = int'(VEC[v][39:32]);
            n    = int'(VEC[v][31:24]);
            seed = int'(VEC[v][23:16]);
            gap  = int'(VEC[v][15:8]);
            ecnt = int'(VEC[v][7:0]);
            start_case();
            if (kind == 2) begin
                for (int i = 0; i < n; i++) begin
                    logic [7:0] p;
                    p = pat(2, seed, i / 8);
                    fb_put(p[i % 8]);
                end
                tag = (n < 25) ? "R5" : ((n < 32) ? "R6" : "R7");
            end else begin
                for (int i = 0; i < n; i++) fb_byte(pat(kind, seed, i));
                fb_add_fcs();
                if (kind == 1) fb[3] = ~fb[3];
                if (kind == 1)       tag = "R7/R3";
                else if (kind == 3)  tag = "R2";
                else if (n < 2)      tag = "R5";
                else                 tag = "R4/R9";
            end
            tx_flag();
            tx_body();
            tx_flag();
            tx_flag();
            expect_from_fb();
            check(exp_n == ecnt, tag, "table expected count", exp_n, ecnt);
            play(gap);
            compare_stream(tag);
            check(cap_ab == 0, tag, "abort pulses", cap_ab, 0);
        end

        // R1 / R10: junk before the first flag, flag at an odd bit offset
        start_case();
        for (int i = 0; i < 3; i++)
            for (int b = 0; b < 8; b++) tx_put(b % 2 == 0);
        tx_put(1'b1); tx_put(1'b0); tx_put(1'b1);
        good_frame(91, 3);
        tx_flag();
        tx_body();
        tx_flag();
        expect_from_fb();
        play(0);
        compare_stream("R1/R10");

        // R12 / R3: two frames sharing one flag
        start_case();
        good_frame(101, 2);
        tx_flag();
        tx_body();
        expect_from_fb();
        good_frame(17, 3);
        tx_flag();
        tx_body();
        tx_flag();
        expect_from_fb();
        play(0);
        compare_stream("R12/R3");

        // R8: abort after six data bytes, then a good frame recovers
        start_case();
        fbn = 0;
        for (int i = 0; i < 5; i++) fb_byte(pat(0, 123, i));
        fb_byte(8'h3C);
        tx_flag();
        tx_body();
        tx_abort();
        expect_prefix(2);
        good_frame(7, 2);
        tx_flag();
        tx_body();
        tx_flag();
        expect_from_fb();
        play(1);
        compare_stream("R8");
        check(cap_ab == 1, "R8", "abort pulses after delivered bytes", cap_ab, 1);

        // R8: abort after four data bytes delivers nothing, no pulse
        start_case();
        fbn = 0;
        for (int i = 0; i < 3; i++) fb_byte(pat(0, 45, i));
        fb_byte(8'h3C);
        tx_flag();
        tx_body();
        tx_abort();
        tx_flag();
        play(0);
        check(cap_n == 0, "R8", "bytes from early abort", cap_n, 0);
        check(cap_ab == 0, "R8", "abort pulse with nothing delivered", cap_ab, 0);

        // R11: long strobe gaps with toggling junk on bit_in
        start_case();
        good_frame(58, 4);
        tx_flag();
        tx_body();
        tx_flag();
        expect_from_fb();
        play(4);
        compare_stream("R11");

        summary();
        $finish;
    end

endmodule